// File: doc/BRIEF.md
# Dual-Channel Digital Down-Converter

This block shifts two real sample streams down in frequency. Both streams are multiplied by one complex tone. The tone comes from a single numerically controlled oscillator, so channel A and channel B always see the same phase on the same sample. The mixed in-phase and quadrature values are reduced to a lower rate by a boxcar average over 2, 4, 8 or 16 samples. Each channel then emits one packed 48-bit word per block.

The oscillator keeps a 24-bit phase that grows by a programmable frequency word on every accepted sample. A one-cycle sync pulse restarts the phase from a programmable initial value. The same pulse throws away any partly filled averaging block. The full 24-bit phase range is one turn, so 0x800000 is half a turn. The sine and cosine values come from a quarter-wave table that is built at elaboration. The table is addressed by the top ten phase bits.

Top module: `ddc_dual_top`

## Requirements
- R1: The phase starts at 0 after reset. Each sample accepted with `smp_valid` is mixed with the current phase, and the phase then advances by `freq_word`, modulo 2^24. In a cycle with neither a sample nor a sync, the phase does not change.
- R2: Channel A and channel B are mixed with the identical cosine and sine values on every sample, so equal inputs give equal output words.
- R3: A `sync_pulse` loads the phase from `phase_init`, where 2^24 counts equal one turn (0x800000 is half a turn). A sample that arrives in the same cycle as the sync is mixed with `phase_init` itself.
- R4: Let m be phase bits [23:14]. The cosine and sine used are round(32767*cos(2*pi*(m+0.5)/1024)) and round(32767*sin(2*pi*(m+0.5)/1024)), rounded half away from zero.
- R5: For a sample x and a table value t, the mixed value is floor((x*t + 64) / 128), saturated to a signed 24-bit range. I uses the cosine and Q uses the sine.
- R6: Each output word carries I in bits [47:24] and Q in bits [23:0], both in two's complement.
- R7: `dec_code` 0, 1, 2 and 3 select block lengths N of 2, 4, 8 and 16. The code is taken when the first sample of a block reaches the averager. Each lane outputs floor(sum of N mixed values / N). `iq_valid` pulses for one cycle per N accepted samples.
- R8: `iq_valid` rises exactly 3 clock edges after the edge that accepts the last sample of a block.
- R9: A sync discards the samples collected so far in the current block. A sample in the same cycle as the sync becomes the first sample of a new block.
- R10: While reset is held, and right after it, `iq_a` and `iq_b` are zero and `iq_valid` is low.
- R11: `iq_a` and `iq_b` hold their last value in every cycle where `iq_valid` is low.
- R12: A change of `freq_word` without a sync takes effect at the next phase step. It applies from the phase update made on the next accepted sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | A sample pair is present this cycle |
| smp_a | input | 16 | Channel A sample, signed |
| smp_b | input | 16 | Channel B sample, signed |
| sync_pulse | input | 1 | Restart the phase and the averaging block |
| freq_word | input | 24 | Phase step per accepted sample |
| phase_init | input | 24 | Phase loaded by a sync |
| dec_code | input | 2 | Block length select: 0, 1, 2, 3 give 2, 4, 8, 16 |
| iq_a | output | 48 | Channel A averaged {I, Q} |
| iq_b | output | 48 | Channel B averaged {I, Q} |
| iq_valid | output | 1 | New words on iq_a and iq_b |

## Verification
A sync pulse and a sample can arrive in the same cycle. In that cycle the block must reload the phase and accept the sample at once, and the sample must then open a fresh averaging block. The bench provokes this in the middle of a partly filled block. It also issues a sync alone between samples. A bench model applies the same priority: on a sync the phase becomes the initial value, the phase for the next sample is the initial value plus the step, and the block count restarts. Every output word and its arrival cycle are compared with that model. The bench also checks that the partial block produced no output.

// File: rtl/ddc_pkg.sv
// Package: ddc_pkg
// Shared widths, the mixed-value type and the block-length decode for the
// down-converter. Assumes a 24-bit phase and 24-bit I/Q results.
package ddc_pkg;
    localparam int PHASE_W   = 24;
    localparam int IQ_W      = 24;
    localparam int MAX_DEC_N = 16;
    localparam int NUM_LANES = 4;

    typedef logic signed [IQ_W-1:0] iq_t;

    // Number of samples averaged for a block-length code.
    function automatic int dec_len(input logic [1:0] code);
        return 2 << code;
    endfunction
endpackage

// File: rtl/ddc_nco.sv
// Module: ddc_nco
// Shared oscillator. It keeps a 24-bit phase, steps it on each accepted
// sample and reloads it on sync. It looks up cosine and sine in a
// quarter-wave table built at elaboration. The table values are registered
// for the accepted sample, one cycle after acceptance.
// Assumes LUT_AW + 2 <= PHASE_W and TRIG_W <= 31.
module ddc_nco import ddc_pkg::*; #(
    parameter int LUT_AW = 8,
    parameter int TRIG_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic                     sync_pulse,
    input  logic [PHASE_W-1:0]       freq_word,
    input  logic [PHASE_W-1:0]       phase_init,
    output logic signed [TRIG_W-1:0] cos_q,
    output logic signed [TRIG_W-1:0] sin_q
);
    localparam int QN  = 1 << LUT_AW;
    localparam int AMP = (1 << (TRIG_W - 1)) - 1;

    // Quarter-wave entry k: sine at (k + 0.5) steps of a quarter turn / QN.
    function automatic int quarter_val(input int k);
        real ang;
        real r;
        ang = 6.283185307179586 * (real'(k) + 0.5) / real'(4 * QN);
        r   = real'(AMP) * $sin(ang);
        return $rtoi(r + 0.5);
    endfunction

    logic [TRIG_W-1:0] qtab [QN];

    for (genvar k = 0; k < QN; k++) begin : g_qtab
        localparam int VAL = quarter_val(k);
        assign qtab[k] = TRIG_W'(VAL);
    end

    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W-1:0] ph_cur;
    logic [1:0]         quad;
    logic [LUT_AW-1:0]  idx;
    logic [LUT_AW-1:0]  ridx;
    logic signed [TRIG_W-1:0] t_fwd, t_rev, cos_c, sin_c;

    assign ph_cur = sync_pulse ? phase_init : phase_q;
    assign quad   = ph_cur[PHASE_W-1 -: 2];
    assign idx    = ph_cur[PHASE_W-3 -: LUT_AW];
    assign ridx   = ~idx;

    // Phase register: reload on sync, step on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (sync_pulse || smp_valid) begin
            phase_q <= ph_cur + (smp_valid ? freq_word : '0);
        end
    end

    // Fold the quarter table into four quadrants for cosine and sine.
    always_comb begin
        t_fwd = signed'(qtab[idx]);
        t_rev = signed'(qtab[ridx]);
        unique case (quad)
            2'd0:    begin sin_c = t_fwd;  cos_c = t_rev;  end
            2'd1:    begin sin_c = t_rev;  cos_c = -t_fwd; end
            2'd2:    begin sin_c = -t_fwd; cos_c = -t_rev; end
            default: begin sin_c = -t_rev; cos_c = t_fwd;  end
        endcase
    end

    // Register the tone values for the sample accepted this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cos_q <= '0;
            sin_q <= '0;
        end else if (smp_valid) begin
            cos_q <= cos_c;
            sin_q <= sin_c;
        end
    end

    // The phase is frozen when there is neither a sample nor a sync.
    assert_phase_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && !sync_pulse) |=> $stable(phase_q));

    // A sync without a sample leaves exactly the initial phase.
    assert_sync_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_pulse && !smp_valid) |=> (phase_q == $past(phase_init)));
endmodule

// File: rtl/ddc_mixer.sv
// Module: ddc_mixer
// Real-by-complex multiplier for one channel. It multiplies the sample by
// cosine (I) and by sine (Q). Each product is rounded half up, shifted by
// MIX_SHIFT and saturated to IQ_W bits. The result is registered once.
// Assumes MIX_SHIFT >= 1 and SMP_W + TRIG_W + 1 >= IQ_W.
module ddc_mixer import ddc_pkg::*; #(
    parameter int SMP_W     = 16,
    parameter int TRIG_W    = 16,
    parameter int MIX_SHIFT = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic signed [SMP_W-1:0]  smp,
    input  logic signed [TRIG_W-1:0] cos_v,
    input  logic signed [TRIG_W-1:0] sin_v,
    output iq_t                      i_o,
    output iq_t                      q_o
);
    localparam int PROD_W = SMP_W + TRIG_W;
    localparam int EXT_W  = PROD_W + 1;
    localparam logic signed [EXT_W-1:0] RND    = EXT_W'(1) << (MIX_SHIFT - 1);
    localparam logic signed [EXT_W-1:0] SAT_HI = EXT_W'((64'sd1 <<< (IQ_W - 1)) - 64'sd1);
    localparam logic signed [EXT_W-1:0] SAT_LO = -SAT_HI - EXT_W'(1);

    // Round half up, scale down and clamp one product.
    function automatic iq_t round_sat(input logic signed [PROD_W-1:0] p);
        logic signed [EXT_W-1:0] r;
        r = (EXT_W'(p) + RND) >>> MIX_SHIFT;
        if (r > SAT_HI) begin
            return SAT_HI[IQ_W-1:0];
        end else if (r < SAT_LO) begin
            return SAT_LO[IQ_W-1:0];
        end
        return r[IQ_W-1:0];
    endfunction

    logic signed [PROD_W-1:0] p_i, p_q;

    assign p_i = smp * cos_v;
    assign p_q = smp * sin_v;

    // Register the scaled I and Q products for each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_o <= '0;
            q_o <= '0;
        end else if (en) begin
            i_o <= round_sat(p_i);
            q_o <= round_sat(p_q);
        end
    end
endmodule

// File: rtl/ddc_boxcar.sv
// Module: ddc_boxcar
// Block averager shared by all I/Q lanes. It sums N mixed values per lane
// and divides by N with an arithmetic shift. It then presents the result
// with a one-cycle valid. The block length is taken when a block starts.
// A sync clears the count and the sums; a value that arrives with the sync
// opens the next block. Assumes lanes arrive together with one valid.
module ddc_boxcar import ddc_pkg::*; #(
    parameter int LANES = NUM_LANES
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       v_in,
    input  logic       s_in,
    input  logic [1:0] dec_code,
    input  iq_t        lane_in  [LANES],
    output iq_t        lane_out [LANES],
    output logic       v_out
);
    localparam int CNT_W = $clog2(MAX_DEC_N);
    localparam int ACC_W = IQ_W + CNT_W;

    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       code_q;
    logic [1:0]       code_eff;
    logic             blk_last;

    assign code_eff = (cnt_q == '0) ? dec_code : code_q;
    assign blk_last = v_in && !s_in && (cnt_q == CNT_W'(dec_len(code_eff) - 1));

    // Block position and the length code held for the running block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            code_q <= '0;
        end else if (s_in) begin
            cnt_q <= v_in ? CNT_W'(1) : '0;
            if (v_in) begin
                code_q <= dec_code;
            end
        end else if (v_in) begin
            cnt_q <= blk_last ? '0 : cnt_q + CNT_W'(1);
            if (cnt_q == '0) begin
                code_q <= dec_code;
            end
        end
    end

    // One strobe per completed block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_out <= 1'b0;
        end else begin
            v_out <= blk_last;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic signed [ACC_W-1:0] acc_q;
        logic signed [ACC_W-1:0] sum_c;

        assign sum_c = acc_q + ACC_W'(lane_in[l]);

        // Running sum for this lane; cleared on sync and at block end.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_q <= '0;
            end else if (s_in) begin
                acc_q <= v_in ? ACC_W'(lane_in[l]) : '0;
            end else if (v_in) begin
                acc_q <= blk_last ? '0 : sum_c;
            end
        end

        // Latch the block average at the block end.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_out[l] <= '0;
            end else if (blk_last) begin
                lane_out[l] <= IQ_W'(sum_c >>> (3'(code_eff) + 3'd1));
            end
        end

        // Outputs change only together with the strobe.
        assert_hold_out_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !v_out |-> $stable(lane_out[l]));
    end

    // A block is at least two samples long, so strobes never touch.
    assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        v_out |=> !v_out);

    // The count stays below the length of the running block.
    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> (int'(cnt_q) < dec_len(code_q)));

    // A sync restarts the count at zero, or at one with a coincident value.
    assert_sync_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        s_in |=> (cnt_q == ($past(v_in) ? CNT_W'(1) : CNT_W'(0))));
endmodule

// File: rtl/ddc_dual_top.sv
// Module: ddc_dual_top
// Two-channel down-converter. One oscillator feeds one mixer per channel,
// and a shared averager follows. Pipeline: the tone and sample registers,
// then the product registers, then the averaged outputs, three edges in all.
// Assumes smp_a and smp_b are sampled together under smp_valid.
module ddc_dual_top import ddc_pkg::*; #(
    parameter int SMP_W     = 16,
    parameter int TRIG_W    = 16,
    parameter int LUT_AW    = 8,
    parameter int MIX_SHIFT = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp_a,
    input  logic signed [SMP_W-1:0] smp_b,
    input  logic                    sync_pulse,
    input  logic [PHASE_W-1:0]      freq_word,
    input  logic [PHASE_W-1:0]      phase_init,
    input  logic [1:0]              dec_code,
    output logic [2*IQ_W-1:0]       iq_a,
    output logic [2*IQ_W-1:0]       iq_b,
    output logic                    iq_valid
);
    localparam int NCH = 2;

    logic signed [SMP_W-1:0]  smp_in [NCH];
    logic signed [SMP_W-1:0]  smp_q  [NCH];
    logic signed [TRIG_W-1:0] cos_q, sin_q;
    logic v1_q, s1_q, v2_q, s2_q;
    iq_t  mix_i [NCH];
    iq_t  mix_q [NCH];
    iq_t  lane_in  [NUM_LANES];
    iq_t  lane_out [NUM_LANES];

    assign smp_in[0] = smp_a;
    assign smp_in[1] = smp_b;

    ddc_nco #(.LUT_AW(LUT_AW), .TRIG_W(TRIG_W)) nco_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .sync_pulse (sync_pulse),
        .freq_word  (freq_word),
        .phase_init (phase_init),
        .cos_q      (cos_q),
        .sin_q      (sin_q)
    );

    // First stage flags that travel with the registered tone values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q <= 1'b0;
            s1_q <= 1'b0;
        end else begin
            v1_q <= smp_valid;
            s1_q <= sync_pulse;
        end
    end

    // Second stage flags that travel with the products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v2_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            v2_q <= v1_q;
            s2_q <= s1_q;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // Capture this channel's sample beside the tone lookup.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                smp_q[c] <= '0;
            end else if (smp_valid) begin
                smp_q[c] <= smp_in[c];
            end
        end

        ddc_mixer #(.SMP_W(SMP_W), .TRIG_W(TRIG_W), .MIX_SHIFT(MIX_SHIFT)) mix_i_u (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (v1_q),
            .smp   (smp_q[c]),
            .cos_v (cos_q),
            .sin_v (sin_q),
            .i_o   (mix_i[c]),
            .q_o   (mix_q[c])
        );

        assign lane_in[2*c]     = mix_i[c];
        assign lane_in[2*c + 1] = mix_q[c];
    end

    ddc_boxcar #(.LANES(NUM_LANES)) avg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .v_in     (v2_q),
        .s_in     (s2_q),
        .dec_code (dec_code),
        .lane_in  (lane_in),
        .lane_out (lane_out),
        .v_out    (iq_valid)
    );

    assign iq_a = {lane_out[0], lane_out[1]};
    assign iq_b = {lane_out[2], lane_out[3]};

    // Every strobe is led by a sample accepted exactly three edges before.
    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        iq_valid |-> $past(smp_valid, 3));
endmodule

// File: tb/ddc_dual_top_tb_top.sv
module ddc_dual_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;
    localparam int VEC_N      = 6;
    localparam int EXP_DEPTH  = 512;

    typedef struct packed {
        logic [23:0] freq;
        logic [23:0] phinit;
        logic [1:0]  code;
        logic [1:0]  kind;
        logic        gap;
        logic [7:0]  n_out;
    } vec_t;

    // Stimulus settings and the number of output words each must produce.
    localparam vec_t VECS [VEC_N] = '{
        '{24'h010000, 24'h000000, 2'd0, 2'd0, 1'b0, 8'd8},
        '{24'h123457, 24'h400000, 2'd1, 2'd1, 1'b0, 8'd4},
        '{24'hF00001, 24'h7FFFF0, 2'd2, 2'd3, 1'b1, 8'd3},
        '{24'h000400, 24'hC00000, 2'd3, 2'd2, 1'b0, 8'd2},
        '{24'h2AAAAA, 24'h0ABCDE, 2'd0, 2'd3, 1'b1, 8'd6},
        '{24'h000000, 24'h200000, 2'd1, 2'd1, 1'b0, 8'd3}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic sync_pulse = 1'b0;
    logic signed [15:0] smp_a = '0;
    logic signed [15:0] smp_b = '0;
    logic [23:0] freq_word = '0;
    logic [23:0] phase_init = '0;
    logic [1:0]  dec_code = '0;
    logic [47:0] iq_a, iq_b;
    logic        iq_valid;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int outs = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;

    logic [23:0] m_ph = '0;
    longint      m_acc [4];
    int          m_cnt = 0;
    int          m_code = 0;
    logic [47:0] e_a [EXP_DEPTH];
    logic [47:0] e_b [EXP_DEPTH];
    int          e_cyc [EXP_DEPTH];
    int          wr = 0;
    int          rd = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ddc_dual_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .smp_a      (smp_a),
        .smp_b      (smp_b),
        .sync_pulse (sync_pulse),
        .freq_word  (freq_word),
        .phase_init (phase_init),
        .dec_code   (dec_code),
        .iq_a       (iq_a),
        .iq_b       (iq_b),
        .iq_valid   (iq_valid)
    );

    function automatic void chk(input bit ok, input string tag,
                                input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endfunction

    // Tone value per the requirement: round half away from zero.
    function automatic longint trig_ref(input logic [23:0] ph, input bit want_sin);
        real ang, r;
        ang = 6.283185307179586 * (real'(int'(ph[23:14])) + 0.5) / 1024.0;
        r   = 32767.0 * (want_sin ? $sin(ang) : $cos(ang));
        return (r >= 0.0) ? longint'($rtoi(r + 0.5)) : -longint'($rtoi(-r + 0.5));
    endfunction

    function automatic longint mix_ref(input longint x, input longint t);
        longint r;
        r = (x * t + 64) >>> 7;
        if (r > 8388607)  r = 8388607;
        if (r < -8388608) r = -8388608;
        return r;
    endfunction

    function automatic logic signed [15:0] wave(input int kind, input int j, input int ch);
        case (kind)
            0:       return 16'(j * 997 - 15000 + ch * 3111);
            1:       return ((j + ch) % 2 == 1) ? 16'sh7FFF : 16'sh8000;
            2:       return 16'(12345 - ch * 30000);
            default: return 16'((j * 40503 + ch * 7919) ^ (j << 5));
        endcase
    endfunction

    // Drive one cycle at a falling edge and advance the model; returns at the next one.
    task automatic drive(input bit v, input logic signed [15:0] a,
                         input logic signed [15:0] b, input bit s);
        logic [23:0] ph_use;
        longint      ln [4];
        longint      ct, st;
        smp_valid  = v;
        smp_a      = a;
        smp_b      = b;
        sync_pulse = s;
        if (s) begin
            ph_use = phase_init;
            m_ph   = phase_init + (v ? freq_word : 24'd0);
            m_cnt  = 0;
            for (int l = 0; l < 4; l++) m_acc[l] = 0;
        end else begin
            ph_use = m_ph;
            if (v) m_ph = m_ph + freq_word;
        end
        if (v) begin
            ct = trig_ref(ph_use, 1'b0);
            st = trig_ref(ph_use, 1'b1);
            ln[0] = mix_ref(longint'(a), ct);
            ln[1] = mix_ref(longint'(a), st);
            ln[2] = mix_ref(longint'(b), ct);
            ln[3] = mix_ref(longint'(b), st);
            if (m_cnt == 0) m_code = int'(dec_code);
            for (int l = 0; l < 4; l++) m_acc[l] += ln[l];
            m_cnt++;
            if (m_cnt == (2 << m_code)) begin
                e_a[wr % EXP_DEPTH] = {24'(m_acc[0] >>> (m_code + 1)), 24'(m_acc[1] >>> (m_code + 1))};
                e_b[wr % EXP_DEPTH] = {24'(m_acc[2] >>> (m_code + 1)), 24'(m_acc[3] >>> (m_code + 1))};
                e_cyc[wr % EXP_DEPTH] = cyc + 3;
                wr++;
                m_cnt = 0;
                for (int l = 0; l < 4; l++) m_acc[l] = 0;
            end
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, '0, '0, 1'b0);
    endtask

    // Output monitor: each strobe must match the next expected word and cycle.
    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            if (iq_valid) begin
                outs++;
                if (rd == wr) begin
                    chk(1'b0, "R7 unexpected output strobe", 64'(iq_a), 64'd0);
                end else begin
                    chk(iq_a == e_a[rd % EXP_DEPTH], "R4 R5 R6 R7 channel A word",
                        64'(iq_a), 64'(e_a[rd % EXP_DEPTH]));
                    chk(iq_b == e_b[rd % EXP_DEPTH], "R1 R4 R5 R6 R7 channel B word",
                        64'(iq_b), 64'(e_b[rd % EXP_DEPTH]));
                    chk(cyc == e_cyc[rd % EXP_DEPTH], "R8 strobe cycle",
                        64'(cyc), 64'(e_cyc[rd % EXP_DEPTH]));
                    rd++;
                end
            end else if (rd < wr && e_cyc[rd % EXP_DEPTH] <= cyc) begin
                chk(1'b0, "R8 missing strobe", 64'(cyc), 64'(e_cyc[rd % EXP_DEPTH]));
                rd++;
            end
        end
    end

    initial begin
        int base;
        for (int l = 0; l < 4; l++) m_acc[l] = 0;
        repeat (4) @(negedge clk);
        chk(iq_valid == 1'b0, "R10 valid low in reset", 64'(iq_valid), 64'd0);
        chk(iq_a == '0, "R10 iq_a zero in reset", 64'(iq_a), 64'd0);
        chk(iq_b == '0, "R10 iq_b zero in reset", 64'(iq_b), 64'd0);
        rst_n  = 1'b1;
        mon_en = 1'b1;
        @(negedge clk);
        chk(iq_valid == 1'b0 && iq_a == '0, "R10 outputs after reset", 64'(iq_a), 64'd0);

        // R1: first samples after reset start at phase zero, not at phase_init.
        freq_word  = 24'h0C0000;
        phase_init = 24'h555555;
        dec_code   = 2'd0;
        base = outs;
        for (int j = 0; j < 4; j++) drive(1'b1, wave(0, j, 0), wave(0, j, 1), 1'b0);
        idle(6);
        chk(outs - base == 2, "R1 R7 outputs from reset phase", 64'(outs - base), 64'd2);

        // Table walk: each vector starts with a lone sync.
        for (int v = 0; v < VEC_N; v++) begin
            int n_smp;
            freq_word  = VECS[v].freq;
            phase_init = VECS[v].phinit;
            dec_code   = VECS[v].code;
            idle(4);
            drive(1'b0, '0, '0, 1'b1);
            base  = outs;
            n_smp = int'(VECS[v].n_out) * (2 << VECS[v].code);
            for (int j = 0; j < n_smp; j++) begin
                drive(1'b1, wave(int'(VECS[v].kind), j, 0), wave(int'(VECS[v].kind), j, 1), 1'b0);
                if (VECS[v].gap && (j % 3 == 1)) idle(2);
            end
            idle(6);
            chk(outs - base == int'(VECS[v].n_out), "R7 output count for vector",
                64'(outs - base), 64'(VECS[v].n_out));
        end

        // R9 R3: sync coinciding with a sample in the middle of a block.
        freq_word  = 24'h031000;
        phase_init = 24'h100000;
        dec_code   = 2'd1;
        idle(4);
        drive(1'b0, '0, '0, 1'b1);
        base = outs;
        drive(1'b1, 16'sd3000, -16'sd7000, 1'b0);
        drive(1'b1, 16'sd9000, 16'sd1000, 1'b0);
        drive(1'b1, -16'sd20000, 16'sd15000, 1'b1);
        for (int j = 0; j < 3; j++) drive(1'b1, wave(3, j, 0), wave(3, j, 1), 1'b0);
        idle(6);
        chk(outs - base == 1, "R9 R3 partial block dropped at coincident sync",
            64'(outs - base), 64'd1);

        // R9: lone sync in the middle of a block.
        base = outs;
        drive(1'b1, 16'sd111, 16'sd222, 1'b0);
        drive(1'b1, 16'sd333, 16'sd444, 1'b0);
        drive(1'b0, '0, '0, 1'b1);
        for (int j = 0; j < 4; j++) drive(1'b1, wave(0, j, 0), wave(0, j, 1), 1'b0);
        idle(6);
        chk(outs - base == 1, "R9 partial block dropped at lone sync", 64'(outs - base), 64'd1);

        // R12: frequency change between samples without a sync.
        dec_code  = 2'd2;
        freq_word = 24'h0A0000;
        idle(3);
        drive(1'b0, '0, '0, 1'b1);
        for (int j = 0; j < 8; j++) begin
            if (j == 3) freq_word = 24'h3F0123;
            drive(1'b1, wave(0, j, 0), wave(3, j, 1), 1'b0);
        end
        idle(6);

        // R3 R2 R11: half-turn initial phase, equal channels, held outputs.
        freq_word  = 24'h000000;
        phase_init = 24'h800000;
        dec_code   = 2'd0;
        idle(3);
        drive(1'b0, '0, '0, 1'b1);
        drive(1'b1, 16'sd1000, 16'sd1000, 1'b0);
        drive(1'b1, 16'sd1000, 16'sd1000, 1'b0);
        idle(8);
        chk($signed(iq_a[47:24]) == -24'sd255992, "R3 R11 I at half turn held",
            64'(iq_a[47:24]), 64'(24'(-255992)));
        chk($signed(iq_a[23:0]) == -24'sd789, "R3 R11 Q at half turn held",
            64'(iq_a[23:0]), 64'(24'(-789)));
        chk(iq_a == iq_b, "R2 equal inputs give equal words", 64'(iq_b), 64'(iq_a));
        chk(rd == wr, "R8 all expected words seen", 64'(rd), 64'(wr));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule